// File: doc/BRIEF.md
# Nibble-Coded Register Access Decoder

This block turns a byte-wide command stream from a host bridge into register reads and writes. Each command byte holds an opcode in bits 7:4 and a 4-bit payload in bits 3:0. Separate commands load the low and high halves of an 8-bit register address. Data bytes are sent the same way, as two halves. The command that carries the upper half of a data byte also commits the write.

Read commands put one byte from the current address into a small reply FIFO. The FIFO drains through a valid/ready output stream. A read can also step the address forward, so consecutive reads walk through adjacent registers. Three registers are decoded: a constant identity register, a scratch register for link testing, and a mode register whose value is driven out to the rest of the chip.

Top module: `nib_reg_decoder`

## Requirements
- R1: The opcodes in bits 7:4 are 0x1 (address low), 0x2 (address high), 0x3 (data low), 0x4 (data high and write) and 0x5 (read). A byte with any other opcode is accepted and has no effect on the address, the registers, the staged nibble or the replies.
- R2: An accepted address-low command replaces address bits 3:0 with its payload. An accepted address-high command replaces address bits 7:4. The other address half is kept.
- R3: A data-low command stages its payload. The next data-high command writes {payload, staged nibble} to the current address and clears the stage. If no nibble is staged, bits 3:0 of the written byte are zero.
- R4: Writes never change the address, so several data pairs after one address all land on that same register.
- R5: Each accepted read command queues exactly one reply byte, holding the value of the current address as it stands after all earlier commands. Replies leave in the order the reads were issued.
- R6: A read whose payload bit 0 is 1 increments the address by one after the read, wrapping from 0xFF to 0x00. With bit 0 clear, the address is unchanged.
- R7: Address 0x00 always reads 0xA6. Writes to it have no effect.
- R8: Address 0x01 reads back the last value written to it, and resets to 0x00.
- R9: Address 0x02 holds the mode byte. It resets to 0x00, reads back the last value written to it, and is driven on mode_o.
- R10: Any other address reads 0x00, and writes to it change no register.
- R11: A reply is offered with rsp_valid_o and held stable until rsp_ready_i is high. cmd_ready_o is low exactly when the reply FIFO (4 entries by default) is full, and a byte offered while it is low is not consumed.
- R12: After reset, cmd_ready_o is 1, rsp_valid_o is 0, mode_o is 0x00, the address is 0x00 and no nibble is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte offered |
| cmd_byte_i | input | 8 | Command byte: opcode in 7:4, payload in 3:0 |
| cmd_ready_o | output | 1 | Command byte consumed on this edge if valid |
| rsp_valid_o | output | 1 | Reply byte available |
| rsp_byte_o | output | 8 | Reply byte |
| rsp_ready_i | input | 1 | Downstream takes the reply byte |
| mode_o | output | 8 | Contents of the mode register |

## Verification
The assertions assume the host keeps to the handshake. A command byte counts only on an edge where both valid and ready are high, and the reply consumer may stall for any number of cycles. The bench drives each command byte at the falling edge and holds it until the design shows ready.

The bench varies rsp_ready_i in three ways: always high, held low long enough to fill the FIFO and stall the decoder, and a repeating two-high/one-low pattern. Within those limits the assertions on FIFO occupancy and reply stability hold.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO  = 4'h1,
    OP_ADDR_HI  = 4'h2,
    OP_DATA_LO  = 4'h3,
    OP_DATA_WR  = 4'h4,
    OP_READ     = 4'h5
  } nrd_op_e;

  localparam logic [BYTE_W-1:0] REG_IDENT   = 8'h00;
  localparam logic [BYTE_W-1:0] REG_SCRATCH = 8'h01;
  localparam logic [BYTE_W-1:0] REG_MODE    = 8'h02;
  localparam logic [BYTE_W-1:0] IDENT_VALUE = 8'hA6;
endpackage

// File: rtl/nrd_cmd_decode.sv
module nrd_cmd_decode
  import nrd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  output logic [BYTE_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_en_o
);
  logic [NIB_W-1:0]  op, nib;
  logic [BYTE_W-1:0] addr_q;
  logic [NIB_W-1:0]  stage_q;
  logic              stage_vld_q;

  assign op  = cmd_byte_i[BYTE_W-1:NIB_W];
  assign nib = cmd_byte_i[NIB_W-1:0];

  always_comb begin
    wr_en_o   = fire_i && (op == OP_DATA_WR);
    rd_en_o   = fire_i && (op == OP_READ);
    wr_data_o = {nib, stage_vld_q ? stage_q : {NIB_W{1'b0}}};
  end

  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      stage_q     <= '0;
      stage_vld_q <= 1'b0;
    end else if (fire_i) begin
      case (op)
        OP_ADDR_LO: addr_q[NIB_W-1:0]      <= nib;
        OP_ADDR_HI: addr_q[BYTE_W-1:NIB_W] <= nib;
        OP_DATA_LO: begin
          stage_q     <= nib;
          stage_vld_q <= 1'b1;
        end
        OP_DATA_WR: stage_vld_q <= 1'b0;
        OP_READ:    if (nib[0]) addr_q <= addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  AST_ADDR_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(addr_o)); // R2
  AST_WRITE_KEEPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> $stable(addr_o)); // R4
  AST_STAGE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> wr_data_o[NIB_W-1:0] == '0); // R3
  AST_READ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && cmd_byte_i[0]) |=> addr_o == $past(addr_o) + 8'd1); // R6
endmodule

// File: rtl/nrd_regs.sv
module nrd_regs
  import nrd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] mode_o
);
  logic [BYTE_W-1:0] scratch_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      mode_q    <= '0;
    end else if (we_i) begin
      if (addr_i == REG_SCRATCH) scratch_q <= wdata_i;
      if (addr_i == REG_MODE)    mode_q    <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      REG_IDENT:   rdata_o = IDENT_VALUE;
      REG_SCRATCH: rdata_o = scratch_q;
      REG_MODE:    rdata_o = mode_q;
      default:     rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;

  AST_SCRATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_SCRATCH) |=> $stable(scratch_q)); // R8
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_MODE) |=> $stable(mode_o)); // R9
endmodule

// File: rtl/nrd_rsp_fifo.sv
module nrd_rsp_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  input  logic             ready_i
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             pop;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign valid_o = (count_q != '0);
  assign data_o  = mem_q[rd_ptr_q];
  assign pop     = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop)    rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R11
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(data_o)); // R11
  AST_PUSH_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> valid_o); // R5
endmodule

// File: rtl/nib_reg_decoder.sv
module nib_reg_decoder
  import nrd_pkg::*;
#(
  parameter int unsigned RSP_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [7:0]  cmd_byte_i,
  output logic        cmd_ready_o,
  output logic        rsp_valid_o,
  output logic [7:0]  rsp_byte_o,
  input  logic        rsp_ready_i,
  output logic [7:0]  mode_o
);
  logic              fire, fifo_full, wr_en, rd_en;
  logic [BYTE_W-1:0] addr, wr_data, rd_data;

  assign cmd_ready_o = !fifo_full;
  assign fire        = cmd_valid_i && cmd_ready_o;

  nrd_cmd_decode u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .cmd_byte_i (cmd_byte_i),
    .addr_o     (addr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .rd_en_o    (rd_en)
  );

  nrd_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .addr_i  (addr),
    .wdata_i (wr_data),
    .rdata_o (rd_data),
    .mode_o  (mode_o)
  );

  nrd_rsp_fifo #(.DEPTH(RSP_DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rd_en),
    .data_i  (rd_data),
    .full_o  (fifo_full),
    .valid_o (rsp_valid_o),
    .data_o  (rsp_byte_o),
    .ready_i (rsp_ready_i)
  );

  AST_STALL_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |-> rsp_valid_o); // R11
  AST_IDENT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && addr == REG_IDENT) |=> rsp_valid_o); // R7
endmodule

// File: tb/nib_reg_decoder_test.sv
module nib_reg_decoder_test;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       rsp_ready = 1'b1;
  logic       cmd_ready, rsp_valid;
  logic [7:0] rsp_byte, mode;

  always #4 clk = ~clk;

  nib_reg_decoder #(.RSP_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte), .cmd_ready_o(cmd_ready),
    .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte), .rsp_ready_i(rsp_ready),
    .mode_o(mode)
  );

  int errors = 0, checks = 0, cyc = 0, rdy_mode = 0;
  string cur_req = "R5";

  // behavioural reference
  logic [7:0] m_addr, m_scratch, m_mode;
  logic [3:0] m_stage;
  bit         m_sv, m_acc;
  logic [7:0] q[$];

  function automatic logic [7:0] m_read(logic [7:0] a);
    if (a == 8'h00) return 8'hA6;
    if (a == 8'h01) return m_scratch;
    if (a == 8'h02) return m_mode;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_addr = 0; m_scratch = 0; m_mode = 0; m_stage = 0; m_sv = 0;
      q.delete();
    end else begin
      m_acc = cmd_valid && (q.size() < DEPTH);
      if (rsp_ready && q.size() > 0) void'(q.pop_front());
      if (m_acc) begin
        case (cmd_byte[7:4])
          4'h1: m_addr[3:0] = cmd_byte[3:0];
          4'h2: m_addr[7:4] = cmd_byte[3:0];
          4'h3: begin m_stage = cmd_byte[3:0]; m_sv = 1; end
          4'h4: begin
            if (m_addr == 8'h01) m_scratch = {cmd_byte[3:0], m_sv ? m_stage : 4'h0};
            if (m_addr == 8'h02) m_mode    = {cmd_byte[3:0], m_sv ? m_stage : 4'h0};
            m_sv = 0;
          end
          4'h5: begin
            q.push_back(m_read(m_addr));
            if (cmd_byte[0]) m_addr = m_addr + 8'd1;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      chk(cmd_ready == (q.size() < DEPTH), "R11", "cmd_ready", cmd_ready, q.size() < DEPTH);
      chk(rsp_valid == (q.size() > 0), "R11", "rsp_valid", rsp_valid, q.size() > 0);
      if (q.size() > 0) chk(rsp_byte == q[0], cur_req, "reply byte", rsp_byte, q[0]);
      chk(mode == m_mode, "R9", "mode", mode, m_mode);
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = 1'b0;
      default: rsp_ready = (cyc % 3) != 0;
    endcase
  end

  task automatic put(logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(logic [7:0] a);
    put({4'h1, a[3:0]});
    put({4'h2, a[7:4]});
  endtask

  task automatic wr(logic [7:0] v);
    put({4'h3, v[3:0]});
    put({4'h4, v[7:4]});
  endtask

  task automatic rd(bit inc);
    put({4'h5, 3'b000, inc});
  endtask

  task automatic drain();
    idle(1);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #21;
    // R12: reset state
    chk(cmd_ready == 1'b1, "R12", "ready in reset", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R12", "valid in reset", rsp_valid, 0);
    chk(mode == 8'h00, "R12", "mode in reset", mode, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    cur_req = "R12"; rd(0); drain();          // address starts at 0x00 -> A6

    cur_req = "R7";
    set_addr(8'h00); rd(0); wr(8'h5A); rd(0); drain();

    cur_req = "R8";
    set_addr(8'h01); wr(8'h55); rd(0); wr(8'hAA); rd(0); drain();

    cur_req = "R4";
    set_addr(8'h01); wr(8'h12); wr(8'h34); wr(8'hC7); rd(0); drain();

    cur_req = "R3";
    put(8'h47); rd(0);                         // no staged nibble -> 0x70
    put(8'h39); put(8'h3B); put(8'h42); rd(0); // last stage wins -> 0x2B
    put(8'h4E); rd(0); drain();                // stage cleared -> 0xE0

    cur_req = "R9";
    set_addr(8'h02); wr(8'h3C); rd(0); drain();
    chk(mode == 8'h3C, "R9", "mode_o after write", mode, 8'h3C);

    cur_req = "R2";
    set_addr(8'h21); put(8'h20); rd(0); put(8'h12); rd(0); drain();

    cur_req = "R10";
    set_addr(8'h10); wr(8'h99); rd(0); set_addr(8'hF1); wr(8'h77); rd(0);
    set_addr(8'h01); rd(0); drain();

    cur_req = "R6";
    set_addr(8'h00); rd(1); rd(1); rd(1); rd(1); rd(0);
    set_addr(8'hFF); rd(1); rd(0); drain();

    cur_req = "R1";
    set_addr(8'h01); put(8'h36);
    put(8'h0F); put(8'h6A); put(8'hF2); put(8'h9C);
    put(8'h41); rd(0);                          // stage survived -> 0x16
    put(8'h70); put(8'hE5); rd(0); drain();     // address still 0x01

    cur_req = "R11";
    rdy_mode = 1;
    set_addr(8'h00);
    fork
      begin
        for (int i = 0; i < 7; i++) rd(i % 2);
      end
      begin
        repeat (20) @(negedge clk);
        chk(cmd_ready == 1'b0, "R11", "stall when full", cmd_ready, 0);
        chk(rsp_valid == 1'b1, "R11", "reply held", rsp_valid, 1);
        rdy_mode = 2;
      end
    join
    cur_req = "R5";
    set_addr(8'h01);
    for (int i = 0; i < 6; i++) begin
      wr(8'(i * 37 + 5)); rd(0);
    end
    drain();
    rdy_mode = 0;
    idle(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule